// File: doc/BRIEF.md
# UART Modem Status Register

This block is the modem status register of a 16550-style serial port. It watches four active-low modem handshake inputs: carrier detect, ring, data set ready and clear to send. It passes each one through a two-flop synchronizer. It reports the inverted level of each input and records any change in a sticky flag. The flags stay set until the register is read.

A diagnostic loopback mode takes the four status levels from the port's own modem control outputs and ignores the pins. Change detection always works on whichever source is selected. The ring flag is set only on the trailing edge of the ring input. The other three flags are set on a change in either direction.

A level interrupt request is raised while any change flag is set and the interrupt enable input is high. A read pulse returns the 32-bit register. In the same cycle it clears the change flags, but a change detected in that cycle is kept.

Top module: `uart_mstat`

## Requirements
- R1: After reset every bit of `rd_data` is 0. Bits 31 to 8 read as 0 at all times.
- R2: With loopback off, bits 7, 6, 5 and 4 are the inverse of `modem_n_i[3]` (carrier), `modem_n_i[2]` (ring), `modem_n_i[1]` (data set ready) and `modem_n_i[0]` (clear to send). A pin held low reads 1. A pin change appears after the second rising clock edge and not after the first.
- R3: With `loop_en` high, bits 7..4 equal `mctl_i[3..0]` in the same cycle. Here `mctl_i[3]` is OUT2, `[2]` is OUT1, `[1]` is DTR and `[0]` is RTS. The pins have no effect on any register bit.
- R4: Bit 3 (carrier), bit 1 (data set ready) and bit 0 (clear to send) are set on a change of their status level in either direction. With loopback off, the flag appears after the third rising edge following the pin change.
- R5: Bit 2 is set only when the ring pin goes from low to high, which is status bit 6 going from 1 to 0. A ring pin going from high to low leaves bit 2 at 0.
- R6: A change flag, once set, stays set without a read, even if its input returns to its earlier level.
- R7: While `rd_en` is high, `rd_data` shows the flags as they were before the read. After that clock edge, flags 3..0 are clear, except that a change detected in the read cycle leaves its flag set.
- R8: `irq` is high exactly while `irq_en` is high and at least one of bits 3..0 is set. It is cleared by a read or by dropping `irq_en`.
- R9: Switching `loop_en` in either direction sets the flag of every line whose selected level differs between the two sources, following the R4/R5 edge rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modem_n_i | input | 4 | Active-low modem pins: [3] carrier, [2] ring, [1] data set ready, [0] clear to send |
| loop_en | input | 1 | Loopback select |
| mctl_i | input | 4 | Modem control outputs: [3] OUT2, [2] OUT1, [1] DTR, [0] RTS |
| irq_en | input | 1 | Modem status interrupt enable |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| rd_data | output | 32 | Register contents |
| irq | output | 1 | Modem status interrupt request (level) |

## Verification
A stale previous-level register shows up one cycle after a pin settles. Either a flag appears that nothing caused, or an expected flag is missing from the next read. A wrong synchronizer depth moves the status bit change by one edge, so the bench samples both before and after the second edge. A mis-ordered clear shows up as a lost flag on the cycle after a read that collides with a change. A wrong edge polarity on the ring line shows up as bit 2 set after the leading edge instead of the trailing edge.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int unsigned LINES    = 4;
  localparam int unsigned IDX_DCD  = 3;
  localparam int unsigned IDX_RING = 2;
  localparam int unsigned IDX_DSR  = 1;
  localparam int unsigned IDX_CTS  = 0;

  typedef enum logic {EDGE_ANY = 1'b0, EDGE_FALL = 1'b1} edge_e;

  // Change rule on the status level (status = inverted pin).
  function automatic logic level_event(input logic prev, input logic cur, input edge_e kind);
    if (kind == EDGE_FALL) return prev & ~cur;
    return prev ^ cur;
  endfunction
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= IDLE;
    else        chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= IDLE;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mstat_delta.sv
module mstat_delta
  import mstat_pkg::*;
#(
  parameter edge_e KIND = EDGE_ANY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic chg_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign chg_o = level_event(prev_q, lvl_i, KIND);
endmodule

// File: rtl/uart_mstat.sv
module uart_mstat
  import mstat_pkg::*;
#(
  parameter int unsigned REG_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] modem_n_i,
  input  logic             loop_en,
  input  logic [LINES-1:0] mctl_i,
  input  logic             irq_en,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  localparam int unsigned LVL_LSB = LINES;
  localparam int unsigned LVL_MSB = 2*LINES - 1;

  logic [LINES-1:0] pin_sync_w;   // synchronized active-low pins
  logic [LINES-1:0] lvl_w;        // selected status levels
  logic [LINES-1:0] chg_w;        // per-line change events
  logic [LINES-1:0] flag_q;

  mstat_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .IDLE('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(modem_n_i), .q_o(pin_sync_w)
  );

  assign lvl_w = loop_en ? mctl_i : ~pin_sync_w;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam edge_e KIND_I = (i == IDX_RING) ? EDGE_FALL : EDGE_ANY;
    mstat_delta #(.KIND(KIND_I)) u_delta (
      .clk(clk), .rst_n(rst_n), .lvl_i(lvl_w[i]), .chg_o(chg_w[i])
    );
  end

  // Read clears first, a same-cycle event sets again.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~{LINES{rd_en}}) | chg_w;
  end

  always_comb begin
    rd_data = '0;
    rd_data[LVL_MSB:LVL_LSB] = lvl_w;
    rd_data[LINES-1:0]       = flag_q;
  end

  assign irq = irq_en & (|flag_q);

  // ---------------- assertions ----------------
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:LVL_MSB+1] == '0);

  assert_loop_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (rd_data[LVL_MSB:LVL_LSB] == mctl_i));

  assert_trail_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[IDX_RING]) |-> (!$past(rd_data[LVL_LSB+IDX_RING]) &&
                                  $past(rd_data[LVL_LSB+IDX_RING], 2)));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ((rd_data[LINES-1:0] & $past(rd_data[LINES-1:0])) == $past(rd_data[LINES-1:0])));

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && chg_w == '0) |=> (rd_data[LINES-1:0] == '0));

  assert_read_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_w != '0) |=> ((rd_data[LINES-1:0] & $past(chg_w)) == $past(chg_w)));

  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chg_w) && irq_en) |=> (irq || !irq_en));
endmodule

// File: tb/uart_mstat_test.sv
module uart_mstat_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  modem_n_i = 4'hF;
  logic        loop_en = 1'b0;
  logic [3:0]  mctl_i = 4'h0;
  logic        irq_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_mstat uut (
    .clk(clk), .rst_n(rst_n), .modem_n_i(modem_n_i), .loop_en(loop_en),
    .mctl_i(mctl_i), .irq_en(irq_en), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(output logic [31:0] d);
    rd_en = 1'b1;
    #1 d = rd_data;
    step(1);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    #1 check("R1 reset value", rd_data, 32'h0);
    check("R8 irq at reset", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_pins_and_delta;
    logic [31:0] d;
    modem_n_i = 4'b0101;
    step(1);
    check("R2 not yet after one edge", {24'h0, rd_data[7:0]}, 32'h0);
    step(1);
    check("R2 status after two edges", {28'h0, rd_data[7:4]}, 32'hA);
    check("R4 flag not before third edge", {28'h0, rd_data[3:0]}, 32'h0);
    step(1);
    check("R4 carrier and dsr flags", {28'h0, rd_data[3:0]}, 32'hA);
    do_read(d);
    check("R7 read returns flags", d, 32'hAA);
    #1 check("R7 flags cleared after read", {28'h0, rd_data[3:0]}, 32'h0);
    check("R1 reserved zero", {8'h0, rd_data[31:8]}, 32'h0);
  endtask

  task automatic t_ring;
    logic [31:0] d;
    modem_n_i = 4'b0001;           // ring pin low, leading edge
    step(4);
    check("R5 ring leading edge no flag", {31'h0, rd_data[2]}, 32'h0);
    check("R2 ring status", {31'h0, rd_data[6]}, 32'h1);
    modem_n_i = 4'b0101;           // ring pin high, trailing edge
    step(4);
    check("R5 ring trailing edge flag", {28'h0, rd_data[3:0]}, 32'h4);
    do_read(d);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    modem_n_i = 4'b0100;
    step(3);
    modem_n_i = 4'b0101;
    step(4);
    check("R6 cts flag kept after return", {28'h0, rd_data[3:0]}, 32'h1);
    do_read(d);
    check("R6 read shows cts flag", {24'h0, d[7:0]}, 32'hA1);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    irq_en = 1'b0;
    modem_n_i = 4'b0100;
    step(4);
    check("R8 irq masked", {31'h0, irq}, 32'h0);
    irq_en = 1'b1;
    #1 check("R8 irq enabled", {31'h0, irq}, 32'h1);
    do_read(d);
    #1 check("R8 irq cleared by read", {31'h0, irq}, 32'h0);
    modem_n_i = 4'b0101;
    step(4);
    check("R8 irq on new change", {31'h0, irq}, 32'h1);
    irq_en = 1'b0;
    #1 check("R8 irq dropped with enable", {31'h0, irq}, 32'h0);
    do_read(d);
    modem_n_i = 4'hF;
    step(4);
    do_read(d);
  endtask

  task automatic t_loop;
    logic [31:0] d;
    loop_en = 1'b1;
    mctl_i = 4'b0000;
    step(1);
    modem_n_i = 4'b0000;
    step(4);
    check("R3 pins ignored in loopback", {24'h0, rd_data[7:0]}, 32'h0);
    mctl_i = 4'b1000;
    #1 check("R3 OUT2 to bit7", {28'h0, rd_data[7:4]}, 32'h8);
    step(1);
    check("R4 carrier flag in loopback", {28'h0, rd_data[3:0]}, 32'h8);
    mctl_i = 4'b0100;
    #1 check("R3 OUT1 to bit6", {28'h0, rd_data[7:4]}, 32'h4);
    step(1);
    check("R5 ring rise in loop no flag", {31'h0, rd_data[2]}, 32'h0);
    mctl_i = 4'b0010;
    step(1);
    check("R5 ring fall in loop sets flag", {28'h0, rd_data[3:0]}, 32'hE);
    check("R3 DTR to bit5", {28'h0, rd_data[7:4]}, 32'h2);
    do_read(d);
    check("R7 read in loop", {24'h0, d[7:0]}, 32'h2E);
    mctl_i = 4'b0000;
    step(1);
    do_read(d);
  endtask

  task automatic t_collide;
    rd_en = 1'b1;
    mctl_i = 4'b0001;
    #1 check("R3 RTS to bit4", {28'h0, rd_data[7:4]}, 32'h1);
    check("R7 read data before event", {28'h0, rd_data[3:0]}, 32'h0);
    step(1);
    rd_en = 1'b0;
    #1 check("R7 event on read cycle kept", {28'h0, rd_data[3:0]}, 32'h1);
  endtask

  task automatic t_modeswitch;
    logic [31:0] d;
    mctl_i = 4'b0000;
    step(1);
    do_read(d);
    loop_en = 1'b0;                // pins all low -> levels all 1
    #1 check("R9 levels from pins", {28'h0, rd_data[7:4]}, 32'hF);
    step(1);
    check("R9 flags on leaving loopback", {28'h0, rd_data[3:0]}, 32'hB);
    do_read(d);
    loop_en = 1'b1;                // mctl 0000 -> levels all 0
    step(1);
    check("R9 flags on entering loopback", {28'h0, rd_data[3:0]}, 32'hF);
  endtask

  initial begin
    step(2);
    t_reset();
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_pins_and_delta();
    t_ring();
    t_sticky();
    t_irq();
    t_loop();
    t_collide();
    t_modeswitch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule